// File: doc/BRIEF.md
# SPI Flash Command Engine

The engine runs one serial flash command at a time for software. The host programs a small byte-wide register file with the chip-select choice, the number of address bytes, a dummy-cycle count, the opcode, a 32-bit flash address and a byte count. It then writes the control byte with the start bit set. The engine drives a single-bit SPI bus in mode 0 and frames the command as follows: opcode, then the selected address bytes, then dummy clocks, then the data phase.

Write data is taken from a 256-byte buffer that the host fills before the start. Read data is stored into the same buffer from index 0, and the host reads it back once the busy bit clears. The control byte also holds a two-bit mode field. This field can be cleared to manual only after a two-write unlock pattern on the opcode register. The clock to the flash is the system clock divided by an even parameter.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset both chip selects are high, SCLK and MOSI are low, and the control byte (offset 0x4) reads 0x30: mode field bits 5:4 = 11, busy bit 1 = 0, direction bit 3 = 0.
- R2: The following registers read back what was written:
  - config bytes at offsets 0x0 to 0x3, little-endian;
  - opcode at 0x5;
  - 16-bit byte count at 0x6 to 0x7;
  - 32-bit address at 0x8 to 0xB.
  Offset 0xC and unused offsets read 0.
- R3: A control write with bits 5:4 = 00 sets the mode field to 00 only if the two register writes just before it were 0x55 and then 0xAA to offset 0x5. Otherwise the field keeps its value. A control write with bits 5:4 = 11 sets it to 11.
- R4: A control write with bit 0 = 1 while idle starts a transaction in the capture cycle. Config bit 24 picks the chip select: 0 drives cs_no[0] low, 1 drives cs_no[1] low. SCLK idles low with a period of SCLK_DIV cycles, high in the second half of each bit. The opcode goes out MSB first, and MOSI changes only at falling edges.
- R5: Config bits 18:16 give the number of address bytes, and values above 4 act as 4. The bytes are sent most significant first and are the low-order bytes of the address register.
- R6: Config bits 23:19 give a count of dummy SCLK cycles, sent after the address with MOSI low.
- R7: With control bit 3 = 1, the data phase sends buffer bytes from index 0 upward, MSB first.
- R8: With control bit 3 = 0, the data phase holds MOSI low. MISO is sampled on rising edges, and each received byte is stored in the buffer from index 0 upward.
- R9: A byte count of 0 ends the transaction after the address and dummy phases. A count above 256 transfers 256 bytes.
- R10: The busy bit reads 1 from the capture cycle until SCLK_DIV cycles after the last falling SCLK edge. Chip select is released for that final gap.
- R11: While busy, a start write has no effect on the bus, and host writes to the buffer are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register byte write strobe |
| reg_addr_i | input | 4 | Register byte offset |
| reg_wdata_i | input | 8 | Register write byte |
| reg_rdata_o | output | 8 | Register read byte at reg_addr_i |
| buf_we_i | input | 1 | Buffer byte write strobe |
| buf_addr_i | input | 8 | Buffer byte index |
| buf_wdata_i | input | 8 | Buffer write byte |
| buf_rdata_o | output | 8 | Buffer byte at buf_addr_i |
| sclk_o | output | 1 | SPI clock |
| mosi_o | output | 1 | Serial data to flash |
| miso_i | input | 1 | Serial data from flash |
| cs_no | output | 2 | Chip selects, active low |

## Verification
The assertions check the following on every cycle:
- at most one chip select is low;
- SCLK and MOSI stay quiet while no device is selected;
- an accepted start raises busy and a select at once;
- no device stays selected while idle;
- a control write without the unlock leaves the mode field untouched.

Only the bench scenarios can show the rest:
- the exact bit stream per phase;
- the address-byte order and the clamping of the address length and byte count;
- the placement of captured read bytes;
- the way a start or buffer write issued mid-transaction changes nothing on the bus.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
  localparam logic [3:0] OFS_CFG0  = 4'h0;
  localparam logic [3:0] OFS_CFG1  = 4'h1;
  localparam logic [3:0] OFS_CFG2  = 4'h2;
  localparam logic [3:0] OFS_CFG3  = 4'h3;
  localparam logic [3:0] OFS_CTRL  = 4'h4;
  localparam logic [3:0] OFS_OPC   = 4'h5;
  localparam logic [3:0] OFS_CNT0  = 4'h6;
  localparam logic [3:0] OFS_CNT1  = 4'h7;
  localparam logic [3:0] OFS_ADR0  = 4'h8;
  localparam logic [3:0] OFS_ADR1  = 4'h9;
  localparam logic [3:0] OFS_ADR2  = 4'hA;
  localparam logic [3:0] OFS_ADR3  = 4'hB;
  localparam logic [7:0] UNLOCK_A  = 8'h55;
  localparam logic [7:0] UNLOCK_B  = 8'hAA;
  localparam logic [2:0] MAX_ALEN  = 3'd4;

  typedef enum logic [2:0] {
    PH_IDLE, PH_CMD, PH_ADDR, PH_DUMMY, PH_DATA, PH_GAP
  } phase_e;

  typedef enum logic [1:0] {ULK_NONE, ULK_HALF, ULK_ARMED} unlock_e;

  typedef struct packed {
    logic        cs_sel;
    logic [2:0]  alen;
    logic [4:0]  dummy;
    logic        dir;
    logic [7:0]  opcode;
    logic [31:0] addr;
  } xfer_cfg_t;
endpackage

// File: rtl/spi_eng_regs.sv
module spi_eng_regs
  import spi_eng_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [3:0]    addr_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o,
  input  logic          busy_i,
  output logic          start_o,
  output xfer_cfg_t     cfg_o,
  output logic [CW-1:0] nbytes_o,
  output logic [1:0]    mode_o,
  output logic          armed_o
);
  logic [31:0] cfg_q, adr_q;
  logic [15:0] cnt_q;
  logic [7:0]  opc_q;
  logic [1:0]  mode_q;
  logic        dir_q;
  unlock_e     ulk_q;
  logic        ctrl_wr;

  assign ctrl_wr = we_i && (addr_i == OFS_CTRL);
  assign start_o = ctrl_wr && wdata_i[0] && !busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      adr_q  <= '0;
      cnt_q  <= '0;
      opc_q  <= '0;
      mode_q <= 2'b11;
      dir_q  <= 1'b0;
      ulk_q  <= ULK_NONE;
    end else if (we_i) begin
      case (addr_i)
        OFS_CFG0: cfg_q[7:0]   <= wdata_i;
        OFS_CFG1: cfg_q[15:8]  <= wdata_i;
        OFS_CFG2: cfg_q[23:16] <= wdata_i;
        OFS_CFG3: cfg_q[31:24] <= wdata_i;
        OFS_OPC:  opc_q        <= wdata_i;
        OFS_CNT0: cnt_q[7:0]   <= wdata_i;
        OFS_CNT1: cnt_q[15:8]  <= wdata_i;
        OFS_ADR0: adr_q[7:0]   <= wdata_i;
        OFS_ADR1: adr_q[15:8]  <= wdata_i;
        OFS_ADR2: adr_q[23:16] <= wdata_i;
        OFS_ADR3: adr_q[31:24] <= wdata_i;
        OFS_CTRL: begin
          dir_q <= wdata_i[3];
          if (wdata_i[5:4] == 2'b11) mode_q <= 2'b11;
          else if (wdata_i[5:4] == 2'b00 && ulk_q == ULK_ARMED) mode_q <= 2'b00;
        end
        default: ;
      endcase
      // unlock tracks only back-to-back opcode writes
      if (addr_i == OFS_OPC && wdata_i == UNLOCK_A) ulk_q <= ULK_HALF;
      else if (addr_i == OFS_OPC && wdata_i == UNLOCK_B && ulk_q == ULK_HALF) ulk_q <= ULK_ARMED;
      else ulk_q <= ULK_NONE;
    end
  end

  always_comb begin
    case (addr_i)
      OFS_CFG0: rdata_o = cfg_q[7:0];
      OFS_CFG1: rdata_o = cfg_q[15:8];
      OFS_CFG2: rdata_o = cfg_q[23:16];
      OFS_CFG3: rdata_o = cfg_q[31:24];
      OFS_CTRL: rdata_o = {2'b00, mode_q, dir_q, 1'b0, busy_i, 1'b0};
      OFS_OPC:  rdata_o = opc_q;
      OFS_CNT0: rdata_o = cnt_q[7:0];
      OFS_CNT1: rdata_o = cnt_q[15:8];
      OFS_ADR0: rdata_o = adr_q[7:0];
      OFS_ADR1: rdata_o = adr_q[15:8];
      OFS_ADR2: rdata_o = adr_q[23:16];
      OFS_ADR3: rdata_o = adr_q[31:24];
      default:  rdata_o = 8'h00;
    endcase
  end

  always_comb begin
    cfg_o.cs_sel = cfg_q[24];
    cfg_o.alen   = (cfg_q[18:16] > MAX_ALEN) ? MAX_ALEN : cfg_q[18:16];
    cfg_o.dummy  = cfg_q[23:19];
    cfg_o.dir    = ctrl_wr ? wdata_i[3] : dir_q;
    cfg_o.opcode = opc_q;
    cfg_o.addr   = adr_q;
  end

  assign nbytes_o = (cnt_q > 16'(DEPTH)) ? CW'(DEPTH) : cnt_q[CW-1:0];
  assign mode_o   = mode_q;
  assign armed_o  = (ulk_q == ULK_ARMED);
endmodule

// File: rtl/spi_eng_buf.sv
module spi_eng_buf #(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          busy_i,
  input  logic          host_we_i,
  input  logic [AW-1:0] host_addr_i,
  input  logic [7:0]    host_wdata_i,
  output logic [7:0]    host_rdata_o,
  input  logic          eng_we_i,
  input  logic [AW-1:0] eng_addr_i,
  input  logic [7:0]    eng_wdata_i,
  output logic [7:0]    eng_rdata_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (eng_we_i) mem_q[eng_addr_i] <= eng_wdata_i;
    else if (host_we_i && !busy_i) mem_q[host_addr_i] <= host_wdata_i;
  end

  assign host_rdata_o = mem_q[host_addr_i];
  assign eng_rdata_o  = mem_q[eng_addr_i];
endmodule

// File: rtl/spi_eng_shift.sv
module spi_eng_shift
  import spi_eng_pkg::*;
#(
  parameter int SCLK_DIV = 4,
  parameter int DEPTH    = 256,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int DW   = $clog2(SCLK_DIV),
  localparam int HALF = SCLK_DIV / 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  xfer_cfg_t     cfg_i,
  input  logic [CW-1:0] nbytes_i,
  output logic          busy_o,
  output logic          sclk_o,
  output logic          mosi_o,
  output logic [1:0]    cs_no,
  input  logic          miso_i,
  output logic [AW-1:0] buf_addr_o,
  input  logic [7:0]    buf_rdata_i,
  output logic          buf_we_o,
  output logic [7:0]    buf_wdata_o
);
  phase_e        ph_q, post_ph;
  xfer_cfg_t     cfg_q;
  logic [CW-1:0] n_q, idx_q;
  logic [DW-1:0] div_q;
  logic [4:0]    bit_q, post_bit;
  logic [7:0]    rx_q, adr_byte;
  logic          sclk_q, half_tick, fall_tick, active;

  assign half_tick = (div_q == DW'(HALF - 1));
  assign fall_tick = half_tick && sclk_q;
  assign active    = (ph_q != PH_IDLE) && (ph_q != PH_GAP);

  // phase that follows the opcode/address bytes
  always_comb begin
    if (cfg_q.dummy != 5'd0) begin
      post_ph = PH_DUMMY; post_bit = cfg_q.dummy - 5'd1;
    end else if (n_q != '0) begin
      post_ph = PH_DATA;  post_bit = 5'd7;
    end else begin
      post_ph = PH_GAP;   post_bit = 5'd0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q <= PH_IDLE; cfg_q <= '0; n_q <= '0; idx_q <= '0;
      div_q <= '0; bit_q <= '0; rx_q <= '0; sclk_q <= 1'b0;
    end else begin
      case (ph_q)
        PH_IDLE: if (start_i) begin
          ph_q <= PH_CMD; cfg_q <= cfg_i; n_q <= nbytes_i;
          bit_q <= 5'd7; div_q <= '0; sclk_q <= 1'b0; idx_q <= '0;
        end
        PH_GAP: begin
          if (div_q == DW'(SCLK_DIV - 1)) begin
            ph_q <= PH_IDLE; div_q <= '0;
          end else div_q <= div_q + 1'b1;
        end
        default: begin
          if (!half_tick) div_q <= div_q + 1'b1;
          else begin
            div_q  <= '0;
            sclk_q <= ~sclk_q;
            if (!sclk_q) rx_q <= {rx_q[6:0], miso_i};
            else if (bit_q != 5'd0) bit_q <= bit_q - 5'd1;
            else begin
              case (ph_q)
                PH_CMD: if (cfg_q.alen != 3'd0) begin
                  ph_q <= PH_ADDR; idx_q <= CW'(cfg_q.alen - 3'd1); bit_q <= 5'd7;
                end else begin
                  ph_q <= post_ph; bit_q <= post_bit; idx_q <= '0;
                end
                PH_ADDR: if (idx_q != '0) begin
                  idx_q <= idx_q - 1'b1; bit_q <= 5'd7;
                end else begin
                  ph_q <= post_ph; bit_q <= post_bit;
                end
                PH_DUMMY: if (n_q != '0) begin
                  ph_q <= PH_DATA; bit_q <= 5'd7; idx_q <= '0;
                end else ph_q <= PH_GAP;
                default: if (idx_q == n_q - 1'b1) ph_q <= PH_GAP;
                         else begin idx_q <= idx_q + 1'b1; bit_q <= 5'd7; end
              endcase
            end
          end
        end
      endcase
    end
  end

  assign adr_byte = 8'(cfg_q.addr >> {idx_q[1:0], 3'b000});

  always_comb begin
    case (ph_q)
      PH_CMD:  mosi_o = cfg_q.opcode[bit_q[2:0]];
      PH_ADDR: mosi_o = adr_byte[bit_q[2:0]];
      PH_DATA: mosi_o = cfg_q.dir && buf_rdata_i[bit_q[2:0]];
      default: mosi_o = 1'b0;
    endcase
  end

  assign busy_o      = (ph_q != PH_IDLE);
  assign sclk_o      = sclk_q;
  assign cs_no       = active ? (cfg_q.cs_sel ? 2'b01 : 2'b10) : 2'b11;
  assign buf_addr_o  = idx_q[AW-1:0];
  assign buf_we_o    = (ph_q == PH_DATA) && !cfg_q.dir && fall_tick && (bit_q == 5'd0);
  assign buf_wdata_o = rx_q;
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_eng_pkg::*;
#(
  parameter int SCLK_DIV  = 4,
  parameter int BUF_DEPTH = 256,
  localparam int AW = $clog2(BUF_DEPTH),
  localparam int CW = $clog2(BUF_DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [3:0]    reg_addr_i,
  input  logic [7:0]    reg_wdata_i,
  output logic [7:0]    reg_rdata_o,
  input  logic          buf_we_i,
  input  logic [AW-1:0] buf_addr_i,
  input  logic [7:0]    buf_wdata_i,
  output logic [7:0]    buf_rdata_o,
  output logic          sclk_o,
  output logic          mosi_o,
  input  logic          miso_i,
  output logic [1:0]    cs_no
);
  xfer_cfg_t     cfg;
  logic [CW-1:0] nbytes;
  logic [AW-1:0] eng_addr;
  logic [7:0]    eng_rdata, eng_wdata;
  logic [1:0]    mode;
  logic          busy, start, eng_we, armed;

  spi_eng_regs #(.DEPTH(BUF_DEPTH)) u_regs (
    .clk_i, .rst_ni, .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o), .busy_i(busy), .start_o(start), .cfg_o(cfg),
    .nbytes_o(nbytes), .mode_o(mode), .armed_o(armed)
  );

  spi_eng_buf #(.DEPTH(BUF_DEPTH)) u_buf (
    .clk_i, .busy_i(busy), .host_we_i(buf_we_i), .host_addr_i(buf_addr_i),
    .host_wdata_i(buf_wdata_i), .host_rdata_o(buf_rdata_o), .eng_we_i(eng_we),
    .eng_addr_i(eng_addr), .eng_wdata_i(eng_wdata), .eng_rdata_o(eng_rdata)
  );

  spi_eng_shift #(.SCLK_DIV(SCLK_DIV), .DEPTH(BUF_DEPTH)) u_shift (
    .clk_i, .rst_ni, .start_i(start), .cfg_i(cfg), .nbytes_i(nbytes), .busy_o(busy),
    .sclk_o, .mosi_o, .cs_no, .miso_i, .buf_addr_o(eng_addr), .buf_rdata_i(eng_rdata),
    .buf_we_o(eng_we), .buf_wdata_o(eng_wdata)
  );
endmodule

// File: rtl/spi_cmd_engine_chk.sv
module spi_cmd_engine_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       reg_we_i,
  input logic [3:0] reg_addr_i,
  input logic [7:0] reg_wdata_i,
  input logic       sclk_o,
  input logic       mosi_o,
  input logic [1:0] cs_no,
  input logic       busy,
  input logic [1:0] mode,
  input logic       armed
);
  logic ctrl_wr;
  assign ctrl_wr = reg_we_i && (reg_addr_i == 4'h4);

  assert_cs_onehot_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cs_no));
  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_no == 2'b11) |-> (!sclk_o && !mosi_o));
  assert_sclk_selected_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_o) |-> (cs_no != 2'b11));
  assert_idle_released_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> (cs_no == 2'b11));
  assert_start_launch_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && reg_wdata_i[0] && !busy) |=> (busy && cs_no != 2'b11));
  assert_mode_locked_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && reg_wdata_i[5:4] == 2'b00 && !armed) |=> $stable(mode));
endmodule

bind spi_cmd_engine spi_cmd_engine_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
  .reg_wdata_i(reg_wdata_i), .sclk_o(sclk_o), .mosi_o(mosi_o), .cs_no(cs_no),
  .busy(busy), .mode(mode), .armed(armed)
);

// File: tb/spi_cmd_engine_test.sv
module spi_cmd_engine_test;
  localparam int CLK_PERIOD = 10;
  localparam int DIV  = 4;
  localparam int HALF = DIV / 2;
  localparam int MAXB = 2400;

  logic       clk = 1'b0, rst_ni = 1'b0;
  logic       reg_we_i = 1'b0, buf_we_i = 1'b0, miso_i = 1'b0;
  logic [3:0] reg_addr_i = 4'h4;
  logic [7:0] reg_wdata_i = 8'h00, buf_addr_i = 8'h00, buf_wdata_i = 8'h00;
  logic [7:0] reg_rdata_o, buf_rdata_o;
  logic       sclk_o, mosi_o;
  logic [1:0] cs_no;

  int compared = 0, mismatched = 0;
  logic exp_bits [MAXB];
  logic so_bits  [MAXB];
  logic [7:0] bmem [256];
  int   m_n = 0, m_t = 0;
  logic m_on = 1'b0, m_sel = 1'b0, pend_start = 1'b0, cmp_en = 1'b0, done = 1'b0;

  spi_cmd_engine #(.SCLK_DIV(DIV), .BUF_DEPTH(256)) uut (
    .clk_i(clk), .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .buf_we_i, .buf_addr_i, .buf_wdata_i, .buf_rdata_o, .sclk_o, .mosi_o, .miso_i, .cs_no
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // reference timing model: t counts edges since the capture edge
  always @(posedge clk) begin
    if (m_on) begin
      m_t = m_t + 1;
      if (m_t >= m_n * DIV + DIV) m_on = 1'b0;
    end
    if (pend_start) begin
      m_on = 1'b1; m_t = 0; pend_start = 1'b0;
    end
  end

  always @(negedge clk) begin
    logic       live, e_sclk, e_mosi;
    logic [1:0] e_cs;
    live   = m_on && (m_t < m_n * DIV);
    e_cs   = live ? (m_sel ? 2'b01 : 2'b10) : 2'b11;
    e_sclk = live && ((m_t % DIV) >= HALF);
    e_mosi = live ? exp_bits[m_t / DIV] : 1'b0;
    if (cmp_en) begin
      compared++;
      if (cs_no !== e_cs || sclk_o !== e_sclk || mosi_o !== e_mosi) begin
        mismatched++;
        $display("FAIL R4 t=%0d cs/sclk/mosi act %b/%b/%b exp %b/%b/%b",
                 m_t, cs_no, sclk_o, mosi_o, e_cs, e_sclk, e_mosi);
      end
      if (!reg_we_i && reg_addr_i == 4'h4) begin
        compared++;
        if (reg_rdata_o[1] !== m_on) begin
          mismatched++;
          $display("FAIL R10 t=%0d busy act %b exp %b", m_t, reg_rdata_o[1], m_on);
        end
      end
    end
    miso_i = live ? so_bits[m_t / DIV] : 1'b0;
  end

  task automatic chk8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s act %02h exp %02h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [3:0] a, input logic [7:0] d, input logic launch);
    @(negedge clk); #1;
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d; pend_start = launch;
    @(negedge clk); #1;
    reg_we_i = 1'b0; reg_addr_i = 4'h4;
  endtask

  task automatic reg_rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); #1;
    reg_addr_i = a; #1; d = reg_rdata_o;
    reg_addr_i = 4'h4;
  endtask

  task automatic buf_wr(input int i, input logic [7:0] d, input logic track);
    @(negedge clk); #1;
    buf_we_i = 1'b1; buf_addr_i = 8'(i); buf_wdata_i = d;
    if (track) bmem[i] = d;
    @(negedge clk); #1;
    buf_we_i = 1'b0;
  endtask

  function automatic logic [7:0] rd_pat(input int i);
    return 8'((i * 73 + 29) ^ (i >> 3));
  endfunction

  task automatic run_txn(input logic sel, input logic [2:0] alen_raw, input logic [4:0] dum,
                         input logic dir, input logic [7:0] op, input logic [31:0] adr,
                         input int cnt, input int poke_at);
    int alen, n, p;
    logic [7:0] by;
    alen = (alen_raw > 3'd4) ? 4 : int'(alen_raw);
    n = (cnt > 256) ? 256 : cnt;
    for (int k = 0; k < MAXB; k++) begin exp_bits[k] = 1'b0; so_bits[k] = 1'b0; end
    p = 0;
    for (int b = 7; b >= 0; b--) begin exp_bits[p] = op[b]; p++; end
    for (int k = alen - 1; k >= 0; k--) begin
      by = 8'(adr >> (8 * k));
      for (int b = 7; b >= 0; b--) begin exp_bits[p] = by[b]; p++; end
    end
    p = p + int'(dum);
    for (int i = 0; i < n; i++) begin
      by = dir ? bmem[i] : rd_pat(i);
      for (int b = 7; b >= 0; b--) begin
        if (dir) exp_bits[p] = by[b]; else so_bits[p] = by[b];
        p++;
      end
    end
    reg_wr(4'h0, 8'h00, 1'b0);
    reg_wr(4'h1, 8'h00, 1'b0);
    reg_wr(4'h2, {dum, alen_raw}, 1'b0);
    reg_wr(4'h3, {7'h00, sel}, 1'b0);
    for (int k = 0; k < 4; k++) reg_wr(4'(8 + k), 8'(adr >> (8 * k)), 1'b0);
    reg_wr(4'h5, op, 1'b0);
    reg_wr(4'h6, 8'(cnt), 1'b0);
    reg_wr(4'h7, 8'(cnt >> 8), 1'b0);
    m_n = p; m_sel = sel;
    reg_wr(4'h4, {4'h3, dir, 3'b001}, 1'b1);
    if (poke_at > 0) begin
      repeat (poke_at) @(negedge clk);
      reg_wr(4'h4, 8'h39, 1'b0);   // R11: start while busy
      buf_wr(n - 1, ~bmem[n - 1], 1'b0); // R11: buffer write while busy
    end
    while (m_on) @(negedge clk);
    if (!dir) for (int i = 0; i < n; i++) bmem[i] = rd_pat(i);
  endtask

  task automatic check_buf(input string tag, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      buf_addr_i = 8'(i); #1;
      chk8(tag, buf_rdata_o, bmem[i]);
    end
  endtask

  task automatic summary;
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] d;
    for (int i = 0; i < 256; i++) bmem[i] = 8'h00;
    repeat (3) @(negedge clk);
    #1 rst_ni = 1'b1;
    cmp_en = 1'b1;

    // R1 reset state
    reg_rd(4'h4, d); chk8("R1 ctrl after reset", d, 8'h30);

    // R2 readback
    reg_wr(4'h0, 8'hA1, 1'b0); reg_wr(4'h3, 8'h5C, 1'b0);
    reg_wr(4'h5, 8'h9F, 1'b0); reg_wr(4'h7, 8'h12, 1'b0);
    reg_wr(4'hB, 8'hC3, 1'b0); reg_wr(4'hC, 8'hFF, 1'b0);
    reg_rd(4'h0, d); chk8("R2 cfg0", d, 8'hA1);
    reg_rd(4'h3, d); chk8("R2 cfg3", d, 8'h5C);
    reg_rd(4'h5, d); chk8("R2 opcode", d, 8'h9F);
    reg_rd(4'h7, d); chk8("R2 count hi", d, 8'h12);
    reg_rd(4'hB, d); chk8("R2 addr3", d, 8'hC3);
    reg_rd(4'hC, d); chk8("R2 offset C", d, 8'h00);

    // R3 unlock sequence
    reg_wr(4'h4, 8'h00, 1'b0);
    reg_rd(4'h4, d); chk8("R3 no unlock", d, 8'h30);
    reg_wr(4'h5, 8'h55, 1'b0); reg_wr(4'h8, 8'h00, 1'b0); reg_wr(4'h5, 8'hAA, 1'b0);
    reg_wr(4'h4, 8'h00, 1'b0);
    reg_rd(4'h4, d); chk8("R3 broken unlock", d, 8'h30);
    reg_wr(4'h5, 8'h55, 1'b0); reg_wr(4'h5, 8'hAA, 1'b0); reg_wr(4'h4, 8'h00, 1'b0);
    reg_rd(4'h4, d); chk8("R3 manual", d, 8'h00);
    reg_wr(4'h4, 8'h30, 1'b0);
    reg_rd(4'h4, d); chk8("R3 back to direct", d, 8'h30);

    // R4 R5 R7: write with 3 address bytes
    for (int i = 0; i < 4; i++) buf_wr(i, 8'(8'h3C + i * 8'h51), 1'b1);
    run_txn(1'b0, 3'd3, 5'd0, 1'b1, 8'h02, 32'hFE123456, 4, 0);
    reg_rd(4'h4, d); chk8("R7 idle after write", d, 8'h38);

    // R6 R8: read, cs1, 4 address bytes, 8 dummies
    run_txn(1'b1, 3'd4, 5'd8, 1'b0, 8'h0B, 32'h89ABCDEF, 5, 0);
    check_buf("R8 read data", 5);

    // R9 zero count, opcode only; R5 clamp of address length 7 -> 4
    run_txn(1'b0, 3'd0, 5'd0, 1'b1, 8'h06, 32'h0, 0, 0);
    run_txn(1'b1, 3'd7, 5'd3, 1'b0, 8'hD8, 32'h01020304, 0, 0);

    // R9 count clamp at 256
    run_txn(1'b0, 3'd1, 5'd0, 1'b0, 8'h03, 32'h00000077, 300, 0);
    check_buf("R9 clamp read", 256);

    // R11 start and buffer write during busy
    for (int i = 0; i < 3; i++) buf_wr(i, 8'(8'hC0 + i), 1'b1);
    run_txn(1'b0, 3'd2, 5'd0, 1'b1, 8'h02, 32'h0000BEEF, 3, 6);
    check_buf("R11 buffer kept", 3);

    repeat (4) @(negedge clk);
    summary();
    $finish;
  end
endmodule